// File: doc/BRIEF.md
# Serial Relay Latch with Coil Boost Timer

This block sits on a relay card. Relay settings arrive one bit at a time on a serial data line. A separate serial clock line moves each bit into a shift chain of five bytes. The bit that falls off the far end of the chain appears on a serial output, so several cards can be wired in a daisy chain and loaded from one data stream. While bits are moving, the relay outputs keep their old values. A strobe pulse then copies the whole chain into holding latches, and those latches drive the active-low relay outputs.

A global enable gates the outputs. When the enable is low, every output sits in the relay-off level. Each strobe also starts a boost request of fixed length. The coil supply uses this request to run at its higher level for that interval, so that relays pull in quickly, and then falls back to its lower holding level.

The serial clock, serial data and strobe inputs are asynchronous to the system clock. Each one passes through a synchroniser, and the serial clock and strobe are then edge-detected before use.

Top module: `relay_chain_latch`

## Requirements
- R1: While reset is asserted, every relay output is 1 (off), the boost request is 0 and the serial output is 0. The shift chain and the latches start cleared.
- R2: Each rising edge of the serial clock shifts one data bit into the chain. After 40 shifts, the first bit shifted in sits in latch bit 39. Latch bit i drives relay output i.
- R3: The serial output shows the chain's oldest bit, which is the one that leaves on the next shift. After n shifts with n of at least 40, it equals bit number n-39 of the stream, counting the first bit as number 1.
- R4: Shifting without a strobe leaves the relay outputs unchanged.
- R5: A rising edge of the strobe copies the chain into the latches. Holding the strobe high does not copy again. A latch bit of 1 drives its relay output to 0 (energised).
- R6: While the enable is low, all relay outputs read 1 in the same cycle. The latched values return when the enable goes high again.
- R7: Each strobe edge sets the boost request high for exactly BOOST_CYCLES system clock cycles. It rises in the same cycle as the latch update.
- R8: A strobe edge that arrives during an active boost restarts the full interval from that edge.
- R9: With the default two-stage synchroniser, a serial clock or strobe edge applied before system clock edge k takes effect at edge k+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_clk_i | input | 1 | Serial shift clock (asynchronous) |
| ser_dat_i | input | 1 | Serial relay data (asynchronous) |
| latch_i | input | 1 | Strobe that copies the chain into the latches |
| out_en_i | input | 1 | Global output enable, active high |
| ser_out_o | output | 1 | Chain overflow bit, for the next card |
| relay_n_o | output | 8*NUM_BYTES | Relay drives, active low |
| boost_o | output | 1 | Request for the higher coil supply |

## Verification
A strobe or serial clock edge driven just before system clock edge k shows up on the latches, the serial output and the boost request after edge k+2. The enable gating takes effect in the same cycle it changes.

The bench drives its inputs on falling edges. It keeps a behavioural model that records the sampled inputs and applies each edge two rising edges later. It compares the model against every output on each falling edge.

The directed checks sample at fixed counts of falling edges:
- The second falling edge after a strobe must still show the old value, and the third must show the new one.
- The boost length is counted in falling-edge samples.
- Enable effects are read one nanosecond after the enable changes.

// File: rtl/relay_chain_latch.sv
module relay_chain_latch #(
  parameter int NUM_BYTES    = 5,
  parameter int BOOST_CYCLES = 25_000_000,
  parameter int SYNC_STAGES  = 2,
  localparam int RELAY_W     = 8 * NUM_BYTES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_clk_i,
  input  logic               ser_dat_i,
  input  logic               latch_i,
  input  logic               out_en_i,
  output logic               ser_out_o,
  output logic [RELAY_W-1:0] relay_n_o,
  output logic               boost_o
);

  localparam int CNT_W = $clog2(BOOST_CYCLES + 1);
  localparam logic [CNT_W-1:0] BOOST_LOAD = CNT_W'(BOOST_CYCLES);

  logic [SYNC_STAGES-1:0] sclk_sync, sdat_sync, stb_sync;
  logic                   sclk_prev, stb_prev;
  logic [RELAY_W-1:0]     chain_q, hold_q;
  logic [CNT_W-1:0]       boost_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_sync <= '0;
      sdat_sync <= '0;
      stb_sync  <= '0;
      sclk_prev <= 1'b0;
      stb_prev  <= 1'b0;
    end else begin
      sclk_sync <= {sclk_sync[SYNC_STAGES-2:0], ser_clk_i};
      sdat_sync <= {sdat_sync[SYNC_STAGES-2:0], ser_dat_i};
      stb_sync  <= {stb_sync[SYNC_STAGES-2:0], latch_i};
      sclk_prev <= sclk_sync[SYNC_STAGES-1];
      stb_prev  <= stb_sync[SYNC_STAGES-1];
    end
  end

  wire shift_en = sclk_sync[SYNC_STAGES-1] & ~sclk_prev;
  wire load_en  = stb_sync[SYNC_STAGES-1] & ~stb_prev;
  wire shift_in = sdat_sync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else if (shift_en) chain_q <= {chain_q[RELAY_W-2:0], shift_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else if (load_en) hold_q <= chain_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) boost_cnt <= '0;
    else if (load_en) boost_cnt <= BOOST_LOAD;
    else if (boost_cnt != '0) boost_cnt <= boost_cnt - 1'b1;
  end

  assign ser_out_o = chain_q[RELAY_W-1];
  assign relay_n_o = out_en_i ? ~hold_q : '1;
  assign boost_o   = (boost_cnt != '0);

endmodule

// File: rtl/relay_chain_latch_chk.sv
module relay_chain_latch_chk #(
  parameter int W = 40
) (
  input logic         clk,
  input logic         rst_n,
  input logic         ser_clk_i,
  input logic         latch_i,
  input logic         out_en_i,
  input logic         ser_out_o,
  input logic [W-1:0] relay_n_o,
  input logic         boost_o
);

  always @(negedge clk)
    if (!rst_n)
      a_r1_reset_state: assert (relay_n_o == '1 && !boost_o && !ser_out_o);

  a_r4_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(relay_n_o) && $stable(out_en_i)) |-> ($past(latch_i, 3) && !$past(latch_i, 4)));

  a_r7_boost_starts_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(latch_i, 3) && !$past(latch_i, 4)) |-> boost_o);

  a_r7_boost_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(boost_o) |-> ($past(latch_i, 3) && !$past(latch_i, 4)));

  a_r3_serout_moves_on_shift: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_out_o) |-> ($past(ser_clk_i, 3) && !$past(ser_clk_i, 4)));

  a_r6_disabled_off: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_en_i) |-> (relay_n_o == '1));

endmodule

bind relay_chain_latch relay_chain_latch_chk #(.W(RELAY_W)) u_chk (.*);

// File: tb/tb_relay_chain_latch.sv
module tb_relay_chain_latch;
  localparam int BOOST = 37;
  localparam int W = 40;

  logic clk = 0, rst_n = 0;
  logic ser_clk_i = 0, ser_dat_i = 0, latch_i = 0, out_en_i = 1;
  logic ser_out_o, boost_o;
  logic [W-1:0] relay_n_o;

  int errors = 0, checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  relay_chain_latch #(.NUM_BYTES(5), .BOOST_CYCLES(BOOST)) dut (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk_i), .ser_dat_i(ser_dat_i),
    .latch_i(latch_i), .out_en_i(out_en_i), .ser_out_o(ser_out_o),
    .relay_n_o(relay_n_o), .boost_o(boost_o));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference: inputs act two rising edges after they are sampled
  bit hc[4], hd[4], hs[4];
  bit [W-1:0] m_chain, m_hold, old;
  int m_cnt;

  always @(posedge clk) begin
    if (!rst_n) begin
      hc = '{default:0}; hd = '{default:0}; hs = '{default:0};
      m_chain = '0; m_hold = '0; m_cnt = 0;
    end else begin
      for (int i = 3; i > 0; i--) begin
        hc[i] = hc[i-1]; hd[i] = hd[i-1]; hs[i] = hs[i-1];
      end
      hc[0] = ser_clk_i; hd[0] = ser_dat_i; hs[0] = latch_i;
      old = m_chain;
      if (hc[2] && !hc[3]) m_chain = {m_chain[W-2:0], hd[2]};
      if (hs[2] && !hs[3]) begin
        m_hold = old;
        m_cnt = BOOST;
      end else if (m_cnt > 0) m_cnt--;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk(relay_n_o === (out_en_i ? ~m_hold : {W{1'b1}}), "R5 model relay", 64'(relay_n_o), 64'(out_en_i ? ~m_hold : {W{1'b1}}));
    chk(ser_out_o === m_chain[W-1], "R3 model serial out", 64'(ser_out_o), 64'(m_chain[W-1]));
    chk(boost_o === (m_cnt != 0), "R7 model boost", 64'(boost_o), 64'(m_cnt != 0));
  end

  task automatic shift_bit(input bit b);
    @(negedge clk); ser_dat_i = b;
    repeat (3) @(negedge clk); ser_clk_i = 1;
    repeat (3) @(negedge clk); ser_clk_i = 0;
  endtask

  task automatic shift_word(input logic [W-1:0] w);
    for (int i = W - 1; i >= 0; i--) shift_bit(w[i]);
    repeat (4) @(negedge clk);
  endtask

  task automatic strobe();
    @(negedge clk); latch_i = 1;
    repeat (4) @(negedge clk); latch_i = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [W-1:0] p1, p2;
    int cnt;
    p1 = 40'hA5_3C_0F_96_E1;
    p2 = 40'h5A_C3_F0_69_1E;
    repeat (3) @(negedge clk);
    chk(relay_n_o === '1, "R1 reset relays off", 64'(relay_n_o), {64{1'b1}} >> 24);
    chk(boost_o === 0 && ser_out_o === 0, "R1 reset boost and serial out", {boost_o, ser_out_o}, 0);
    rst_n = 1;

    shift_word(p1);
    chk(relay_n_o === '1, "R4 no change while shifting", 64'(relay_n_o), {64{1'b1}} >> 24);
    chk(ser_out_o === p1[39], "R3 first bit at serial out", ser_out_o, p1[39]);

    // R9 latency of strobe, then R7 rise with latch update
    @(negedge clk); latch_i = 1;
    @(negedge clk);
    @(negedge clk);
    chk(boost_o === 0 && relay_n_o === '1, "R9 no effect after two edges", {boost_o, 8'(relay_n_o)}, 9'h0FF);
    @(negedge clk);
    chk(boost_o === 1, "R7 boost rises with latch update", boost_o, 1);
    chk(relay_n_o === ~p1, "R5 latched active low", 64'(relay_n_o), 64'(~p1));
    chk(relay_n_o[0] === ~p1[0] && relay_n_o[39] === ~p1[39], "R2 bit order", {relay_n_o[39], relay_n_o[0]}, {~p1[39], ~p1[0]});
    repeat (3) @(negedge clk); latch_i = 0;

    // R6 enable gating
    @(negedge clk); out_en_i = 0; #1;
    chk(relay_n_o === '1, "R6 disabled all off", 64'(relay_n_o), {64{1'b1}} >> 24);
    @(negedge clk); out_en_i = 1; #1;
    chk(relay_n_o === ~p1, "R6 latched values return", 64'(relay_n_o), 64'(~p1));

    repeat (BOOST + 10) @(negedge clk);
    chk(boost_o === 0, "R7 boost ended", boost_o, 0);

    // R3 overflow continues in stream order
    shift_word(p2);
    chk(ser_out_o === p2[39], "R3 serial out after 40", ser_out_o, p2[39]);
    chk(relay_n_o === ~p1, "R4 outputs held during second word", 64'(relay_n_o), 64'(~p1));
    shift_bit(1'b0); repeat (4) @(negedge clk);
    chk(ser_out_o === p2[38], "R3 serial out after 41", ser_out_o, p2[38]);
    shift_bit(1'b1); shift_bit(1'b1); repeat (4) @(negedge clk);
    chk(ser_out_o === p2[36], "R3 serial out after 43", ser_out_o, p2[36]);

    // R7 exact boost length, and held strobe loads once (R5)
    cnt = 0;
    @(negedge clk); latch_i = 1;
    for (int i = 0; i < BOOST + 30; i++) begin
      @(negedge clk);
      if (boost_o) cnt++;
    end
    latch_i = 0;
    chk(cnt == BOOST, "R7 boost length", cnt, BOOST);
    chk(relay_n_o === ~{p2[36:0], 3'b011}, "R5 second load", 64'(relay_n_o), 64'(~{p2[36:0], 3'b011}));

    // R8 restart during boost
    repeat (5) @(negedge clk);
    cnt = 0;
    @(negedge clk); latch_i = 1;
    for (int i = 0; i < 2 * BOOST + 40; i++) begin
      @(negedge clk);
      if (boost_o) cnt++;
      if (i == 3) latch_i = 0;
      if (i == 14) latch_i = 1;
      if (i == 18) latch_i = 0;
    end
    chk(cnt == BOOST + 15, "R8 restart length", cnt, BOOST + 15);

    // R2 load while disabled stays off until enabled
    out_en_i = 0;
    shift_word(p1);
    strobe();
    chk(relay_n_o === '1, "R6 load while disabled", 64'(relay_n_o), {64{1'b1}} >> 24);
    @(negedge clk); out_en_i = 1; #1;
    chk(relay_n_o === ~p1, "R2 word after enable", 64'(relay_n_o), 64'(~p1));

    repeat (BOOST + 5) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule